// File: doc/BRIEF.md
# ROM Checksum Self-Test Engine

This engine verifies the contents of a read-only memory against a reference sum kept in the memory's own top locations. After a start pulse it reads every address once, from the lowest to the highest, through a synchronous read port that returns data one cycle after the request. It adds up the data words in a wide accumulator and collects the reference words. It then compares the two, raises a one-cycle completion pulse and reports a pass/fail flag. The engine needs no knowledge of the memory contents. It only needs to know how the reference is stored.

The reference can take one of two forms. In the full form it spans several words, with the lowest address holding the least significant part. In the truncated form it is a single word in the top location that holds either the low or the high slice of the sum; the rest of the sum is discarded. The storage mode is sampled at start and held for the whole run. The check cannot see faults that leave the sum unchanged. An all-zero memory always passes, and errors of opposite sign in different words cancel out.

Top module: `rom_checksum_test`

## Requirements
- R1: An accepted start causes exactly 2^ADDR_W reads, one per cycle, at addresses 0, 1, 2 up to the last address, with no gaps. `rom_en` is high only during those read cycles.
- R2: The data words are the addresses below DEPTH - NREF. NREF is 1 in truncated mode and the effective word count in full mode. Their sum is kept modulo 2^(DATA_W*MAX_CSW), so carries propagate into the higher words.
- R3: In full mode (`trunc_en`=0), the reference spans the top NREF addresses, with the lowest of them holding the least significant word. `pass` is 1 exactly when the lowest NREF words of the sum equal these words.
- R4: In truncated mode with `trunc_hi`=0, the word at the top address is compared with bits [DATA_W-1:0] of the sum.
- R5: In truncated mode with `trunc_hi`=1, the word at the top address is compared with sum word number (effective count - 1), that is bits [DATA_W*count-1 : DATA_W*(count-1)].
- R6: A `csw_cnt` of 0 is treated as 1, and a value above MAX_CSW is treated as MAX_CSW.
- R7: `csw_cnt`, `trunc_en` and `trunc_hi` are sampled only at an accepted start. A start while `busy` is high is ignored, and so are mode changes during a run.
- R8: `busy` rises on the clock edge that accepts start and stays high for 2^ADDR_W + 2 cycles. `done` is a one-cycle pulse on the edge where `busy` falls.
- R9: After reset, `busy`, `done`, `pass` and `rom_en` are 0. `pass` changes only together with `done` and holds its value until the next run completes.
- R10: Faults that leave the sum unchanged pass the check. These include an all-zero memory and offsetting +1/-1 changes in two data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches a run when idle |
| csw_cnt | input | $clog2(MAX_CSW+1) | Number of reference words (full mode); selects the high slice index in truncated mode |
| trunc_en | input | 1 | 1: a single truncated reference word |
| trunc_hi | input | 1 | With trunc_en: 1 compares the upper slice, 0 the lower |
| rom_en | output | 1 | Memory read request |
| rom_addr | output | ADDR_W | Memory read address |
| rom_data | input | DATA_W | Read data, valid the cycle after the request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last completed run |

## Verification
The bench uses DATA_W=8, ADDR_W=4 and MAX_CSW=3, which gives a 16-word memory. Each run is short, so many storage modes fit in a short run time. Three reference words allow multi-word sums. A memory filled with 0xFF carries into the second word, so the upper-slice comparison and the effective word count of 3 are exercised with real carry content. The small address space also makes it cheap to check that every address is visited in order on each run.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2,
    ST_CMP  = 2'd3
  } rcs_state_e;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int MAX_CSW = 2,
  parameter int CSW_W   = 2,
  parameter int IDX_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CSW_W-1:0]  csw_cnt,
  input  logic              trunc_en,
  input  logic              trunc_hi,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              busy,
  output logic              accept,
  output logic              tag_vld,
  output logic              tag_ref,
  output logic [IDX_W-1:0]  tag_idx,
  output logic              cmp_go,
  output logic [CSW_W-1:0]  nwords_q,
  output logic              trunc_q,
  output logic              hi_q
);
  localparam logic [ADDR_W-1:0] LAST_A  = '1;
  localparam logic [ADDR_W:0]   DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  rcs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic [CSW_W-1:0]  nw_in;
  logic [ADDR_W:0]   nref, first_ref;
  logic              is_ref;
  logic [IDX_W-1:0]  idx;
  logic              tag_last_q;

  // clamp of the requested word count (R6)
  always_comb begin
    if (csw_cnt == '0)                      nw_in = CSW_W'(1);
    else if (csw_cnt > CSW_W'(MAX_CSW))     nw_in = CSW_W'(MAX_CSW);
    else                                    nw_in = csw_cnt;
  end

  assign accept    = (state_q == ST_IDLE) && start;
  assign nref      = trunc_q ? (ADDR_W+1)'(1) : (ADDR_W+1)'(nwords_q);
  assign first_ref = DEPTH_V - nref;
  assign is_ref    = {1'b0, cnt_q} >= first_ref;
  assign idx       = IDX_W'({1'b0, cnt_q} - first_ref);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_A) state_d = ST_WAIT;
      end
      ST_WAIT: if (tag_last_q) state_d = ST_CMP;
      ST_CMP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nwords_q <= CSW_W'(1);
      trunc_q  <= 1'b0;
      hi_q     <= 1'b0;
    end else if (accept) begin
      nwords_q <= nw_in;
      trunc_q  <= trunc_en;
      hi_q     <= trunc_hi;
    end
  end

  // tags travel with each read to meet its data one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_vld    <= 1'b0;
      tag_ref    <= 1'b0;
      tag_idx    <= '0;
      tag_last_q <= 1'b0;
    end else begin
      tag_vld    <= rom_en;
      tag_ref    <= is_ref;
      tag_idx    <= idx;
      tag_last_q <= rom_en && (cnt_q == LAST_A);
    end
  end

  assign rom_en   = (state_q == ST_RUN);
  assign rom_addr = cnt_q;
  assign busy     = (state_q != ST_IDLE);
  assign cmp_go   = (state_q == ST_CMP);
endmodule

// File: rtl/rcs_accum.sv
module rcs_accum #(
  parameter int DATA_W  = 8,
  parameter int MAX_CSW = 2,
  parameter int IDX_W   = 1,
  localparam int ACC_W  = DATA_W * MAX_CSW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tag_vld,
  input  logic              tag_ref,
  input  logic [IDX_W-1:0]  tag_idx,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  refw
);
  logic acc_en;
  assign acc_en = tag_vld && !tag_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (acc_en) acc_q <= acc_q + ACC_W'(rom_data);
  end

  for (genvar w = 0; w < MAX_CSW; w++) begin : g_ref
    logic [DATA_W-1:0] word_q;
    logic              word_en;
    assign word_en = tag_vld && tag_ref && (tag_idx == IDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= rom_data;
    end
    assign refw[w*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/rcs_cmp.sv
module rcs_cmp #(
  parameter int DATA_W  = 8,
  parameter int MAX_CSW = 2,
  parameter int CSW_W   = 2,
  localparam int ACC_W  = DATA_W * MAX_CSW
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] refw,
  input  logic [CSW_W-1:0] nwords,
  input  logic             trunc,
  input  logic             hi,
  output logic             match
);
  logic [MAX_CSW-1:0] eq, need;
  logic [DATA_W-1:0]  hi_word, sel_word;

  for (genvar w = 0; w < MAX_CSW; w++) begin : g_word
    assign eq[w]   = acc[w*DATA_W +: DATA_W] == refw[w*DATA_W +: DATA_W];
    assign need[w] = nwords > CSW_W'(w);
  end

  always_comb begin
    hi_word = '0;
    for (int i = 0; i < MAX_CSW; i++)
      if (nwords == CSW_W'(i + 1)) hi_word = acc[i*DATA_W +: DATA_W];
  end

  assign sel_word = hi ? hi_word : acc[DATA_W-1:0];
  assign match    = trunc ? (sel_word == refw[DATA_W-1:0]) : &(eq | ~need);
endmodule

// File: rtl/rom_checksum_test.sv
module rom_checksum_test #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int MAX_CSW = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(MAX_CSW+1)-1:0] csw_cnt,
  input  logic                         trunc_en,
  input  logic                         trunc_hi,
  output logic                         rom_en,
  output logic [ADDR_W-1:0]            rom_addr,
  input  logic [DATA_W-1:0]            rom_data,
  output logic                         busy,
  output logic                         done,
  output logic                         pass
);
  localparam int CSW_W = $clog2(MAX_CSW + 1);
  localparam int IDX_W = (MAX_CSW > 1) ? $clog2(MAX_CSW) : 1;
  localparam int ACC_W = DATA_W * MAX_CSW;

  logic [1:0]        rst_sync;
  logic              rst_i;
  logic              accept, tag_vld, tag_ref, cmp_go, trunc_q, hi_q, match;
  logic [IDX_W-1:0]  tag_idx;
  logic [CSW_W-1:0]  nwords_q;
  logic [ACC_W-1:0]  acc, refw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  rcs_ctrl #(.ADDR_W(ADDR_W), .MAX_CSW(MAX_CSW), .CSW_W(CSW_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .csw_cnt(csw_cnt),
    .trunc_en(trunc_en), .trunc_hi(trunc_hi), .rom_en(rom_en), .rom_addr(rom_addr),
    .busy(busy), .accept(accept), .tag_vld(tag_vld), .tag_ref(tag_ref),
    .tag_idx(tag_idx), .cmp_go(cmp_go), .nwords_q(nwords_q),
    .trunc_q(trunc_q), .hi_q(hi_q)
  );

  rcs_accum #(.DATA_W(DATA_W), .MAX_CSW(MAX_CSW), .IDX_W(IDX_W)) u_accum (
    .clk(clk), .rst_n(rst_i), .clr(accept), .tag_vld(tag_vld), .tag_ref(tag_ref),
    .tag_idx(tag_idx), .rom_data(rom_data), .acc_q(acc), .refw(refw)
  );

  rcs_cmp #(.DATA_W(DATA_W), .MAX_CSW(MAX_CSW), .CSW_W(CSW_W)) u_cmp (
    .acc(acc), .refw(refw), .nwords(nwords_q), .trunc(trunc_q), .hi(hi_q), .match(match)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      done <= 1'b0;
      pass <= 1'b0;
    end else begin
      done <= cmp_go;
      if (cmp_go) pass <= match;
    end
  end
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rom_en,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              busy,
  input logic              done,
  input logic              pass
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_en && $past(rom_en)) |-> (rom_addr == ADDR_W'($past(rom_addr) + 1'b1))); // R1
  AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_en) |-> (rom_addr == '0)); // R1
  AST_ADDR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_en) |-> ($past(rom_addr) == {ADDR_W{1'b1}})); // R1
  AST_EN_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> busy); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass) |-> done); // R9
endmodule

bind rom_checksum_test rcs_chk #(.ADDR_W(ADDR_W)) u_rcs_chk (
  .clk(clk), .rst_n(rst_n), .rom_en(rom_en), .rom_addr(rom_addr),
  .busy(busy), .done(done), .pass(pass)
);

// File: tb/rom_checksum_test_test.sv
module rom_checksum_test_test;
  localparam int DW = 8, AW = 4, MC = 3, CW = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] csw_cnt = '0;
  logic          trunc_en = 1'b0, trunc_hi = 1'b0;
  logic          rom_en, busy, done, pass;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic [DW-1:0] mem [DEPTH];

  int n_chk = 0, n_err = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rom_checksum_test #(.DATA_W(DW), .ADDR_W(AW), .MAX_CSW(MC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .csw_cnt(csw_cnt),
    .trunc_en(trunc_en), .trunc_hi(trunc_hi), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_data), .busy(busy), .done(done), .pass(pass)
  );

  always @(posedge clk) if (rom_en) rom_data <= mem[rom_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected done", 1, 0);
      else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(pass == e, t, "pass result", int'(pass), int'(e));
      end
    end
  end

  function automatic int eff_n(input int n);
    return (n == 0) ? 1 : ((n > MC) ? MC : n);
  endfunction

  function automatic longint data_sum(input int nref);
    longint s = 0;
    for (int a = 0; a < DEPTH - nref; a++) s += mem[a];
    return s & ((64'd1 << (DW*MC)) - 1);
  endfunction

  function automatic bit model(input int n, input bit te, input bit th);
    int     ne = eff_n(n);
    longint s  = data_sum(te ? 1 : ne);
    if (te) begin
      longint w = th ? ((s >> (DW*(ne-1))) & 255) : (s & 255);
      return w == longint'(mem[DEPTH-1]);
    end
    for (int i = 0; i < ne; i++)
      if (((s >> (DW*i)) & 255) != longint'(mem[DEPTH-ne+i])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic put_ref(input int n, input bit te, input bit th);
    int     ne = eff_n(n);
    longint s  = data_sum(te ? 1 : ne);
    if (te) mem[DEPTH-1] = th ? DW'(s >> (DW*(ne-1))) : DW'(s);
    else for (int i = 0; i < ne; i++) mem[DEPTH-ne+i] = DW'(s >> (DW*i));
  endtask

  task automatic fill(input int kind);
    for (int a = 0; a < DEPTH; a++)
      case (kind)
        0: mem[a] = DW'(a*37 + 11);
        1: mem[a] = 8'hFF;
        default: mem[a] = 8'h00;
      endcase
  endtask

  // one run: push expectation, launch, watch addresses and busy length
  task automatic run(input int n, input bit te, input bit th, input string tag,
                     input bit poke);
    int bcnt = 0, nxt = 0, bad = 0;
    exp_q.push_back(model(n, te, th));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b1; csw_cnt = CW'(n); trunc_en = te; trunc_hi = th;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (busy) bcnt++;
      if (rom_en) begin
        if (int'(rom_addr) != nxt) bad++;
        nxt++;
      end
      if (poke) begin
        if (bcnt == 3) begin
          start = 1'b1; csw_cnt = CW'(1); trunc_en = ~te; trunc_hi = ~th;
        end else start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(bcnt == DEPTH + 2, "R8", "busy cycles", bcnt, DEPTH + 2);
    chk(bad == 0 && nxt == DEPTH, "R1", "read count in order", nxt - bad, DEPTH);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk({busy, done, pass, rom_en} == 4'b0, "R9", "reset outputs",
        int'({busy, done, pass, rom_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 full mode, several word counts
    fill(0); put_ref(1, 0, 0); run(1, 0, 0, "R3", 0);
    fill(0); put_ref(2, 0, 0); run(2, 0, 0, "R3", 0);
    mem[DEPTH-1] ^= 8'h10;     run(2, 0, 0, "R3", 0);
    // R2 carries into upper words
    fill(1); put_ref(3, 0, 0); run(3, 0, 0, "R2", 0);
    mem[DEPTH-1] = 8'h01;      run(3, 0, 0, "R2", 0);
    // R4 low truncation
    fill(0); put_ref(2, 1, 0); run(2, 1, 0, "R4", 0);
    mem[DEPTH-1] ^= 8'h01;     run(2, 1, 0, "R4", 0);
    // R5 high truncation
    fill(1); put_ref(2, 1, 1); run(2, 1, 1, "R5", 0);
    put_ref(2, 1, 0);          run(2, 1, 1, "R5", 0);
    // R9 pass holds after a failing run
    repeat (4) @(negedge clk);
    chk(pass == 1'b0, "R9", "pass held low", int'(pass), 0);
    // R6 zero count acts as one
    fill(0); put_ref(1, 0, 0); run(0, 0, 0, "R6", 0);
    repeat (4) @(negedge clk);
    chk(pass == 1'b1, "R9", "pass held high", int'(pass), 1);
    // R7 start and modes ignored while busy
    fill(0); put_ref(3, 0, 0); run(3, 0, 0, "R7", 1);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R7", "no relaunch", int'(busy), 0);
    // R10 blind spots
    fill(2); run(2, 0, 0, "R10", 0);
    fill(0); put_ref(2, 0, 0);
    mem[2] = mem[2] + 8'd1; mem[5] = mem[5] - 8'd1;
    run(2, 0, 0, "R10", 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule